// File: doc/BRIEF.md
# Keyed Watchdog Reset Timer

This block guards a processor against hung code. Software arms it by writing an arm key byte to a single service register. That write loads a down counter with one of four timeout periods, and the counter then runs down. If software writes the clear key before the count runs out, the countdown stops and nothing happens. If the count expires while the timer is armed, the block drives a system reset pulse of fixed width. It also sets a sticky flag, so that code running after the reset can tell that a timeout caused it.

The four periods step up by a factor of four. The shortest is a parameter in clock cycles, and the others are that value shifted left by 2, 4 and 6 bits. The period is captured at the moment of arming. A configuration input switches the whole mechanism off while it is high.

The control is a three-state machine:
- IDLE: the timer is not armed.
- COUNT: the countdown is running.
- FIRE: the reset pulse is being driven.

Its transitions are:
- `arm` moves IDLE to COUNT. An arm write while in COUNT reloads the counter and stays in COUNT.
- `clear` moves COUNT to IDLE.
- `disable` moves COUNT to IDLE.
- `expire` moves COUNT to FIRE.
- `pulse_done` moves FIRE to IDLE.

Top module: `wdt_keyed_top`

## Requirements
- R1: After `por_n` is low, `sys_rst` and `timeout_flag` are 0 and the timer is idle.
- R2: A write of 0x55 to address `SVC_ADDR` while `wdt_off` is 0 arms the timer. With no further key write, `sys_rst` rises exactly P cycles after the clock edge that captured the arm write.
- R3: P equals `BASE_CYCLES << (2*rate_sel)`. For `rate_sel` values 0, 1, 2 and 3 this is the base value times 1, 4, 16 and 64.
- R4: A write of 0xAA to `SVC_ADDR` while armed stops the countdown, and no pulse follows. This also holds when the clear write is captured on the same edge that would have expired the count.
- R5: Writes of any other byte to `SVC_ADDR`, and any write to another address, change nothing. A running countdown keeps its original expiry, and an idle timer stays idle.
- R6: An arm write while armed reloads the counter. The pulse then comes P cycles after the latest arm write.
- R7: `rate_sel` is sampled only on the arm write. Later changes do not alter the running period.
- R8: `sys_rst` stays high for exactly `PULSE_W` cycles, and then the timer is idle. Key writes during the pulse are ignored.
- R9: `timeout_flag` rises together with `sys_rst`. It stays 1 through later key writes, and only `por_n` clears it.
- R10: While `wdt_off` is 1, key writes are ignored. Raising `wdt_off` during a countdown stops it without a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| wdt_off | input | 1 | Configuration bit; 1 switches the watchdog off |
| rate_sel | input | 2 | Timeout period select |
| sys_rst | output | 1 | System reset pulse, active high |
| timeout_flag | output | 1 | Sticky timeout indicator |

## Verification
Assertions check the following on every cycle:
- that the flag, once set, stays set;
- that a clear write or a raised `wdt_off` ends a countdown on the next edge;
- that the counter either reloads on an arm write or drops by exactly one;
- that a finished pulse returns the machine to idle.

The exact cycle of the rising edge for each of the four periods needs the bench's sweep. So do the clear captured on the final edge, the reload on re-arm, and the insensitivity to later `rate_sel` changes. These all depend on the arithmetic relation between the write edge and the output over a long window.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRE  = 2'd2
    } wdt_state_e;

    localparam logic [7:0] KEY_ARM = 8'h55;
    localparam logic [7:0] KEY_CLR = 8'hAA;

    typedef struct packed {
        logic arm;
        logic clr;
    } wdt_cmd_t;

endpackage

// File: rtl/wdt_key_decode.sv
module wdt_key_decode
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] SVC_ADDR = '0
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              enable,
    output wdt_cmd_t          cmd
);
    logic hit;

    always_comb begin
        hit     = wr_en && enable && (wr_addr == SVC_ADDR);
        cmd.arm = hit && (wr_data == KEY_ARM);
        cmd.clr = hit && (wr_data == KEY_CLR);
    end
endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel #(
    parameter int BASE_CYCLES = 16,
    parameter int CNT_W = 11
) (
    input  logic [1:0]       rate,
    output logic [CNT_W-1:0] period
);
    logic [CNT_W-1:0] tbl [4];

    for (genvar g = 0; g < 4; g++) begin : g_rate
        assign tbl[g] = CNT_W'(BASE_CYCLES) << (2 * g);
    end

    assign period = tbl[rate];
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - CNT_W'(1);
    end

    assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] SVC_ADDR = 4'h3,
    parameter int BASE_CYCLES = 16,
    parameter int PULSE_W = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              wdt_off,
    input  logic [1:0]        rate_sel,
    output logic              sys_rst,
    output logic              timeout_flag
);
    localparam int CNT_W = $clog2(BASE_CYCLES * 64 + 1);
    localparam int PW_W  = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;

    wdt_state_e       state, state_nx;
    wdt_cmd_t         cmd;
    logic [CNT_W-1:0] load_val, cnt;
    logic             cnt_last, cnt_load, cnt_dec;
    logic [PW_W-1:0]  pcnt;
    logic             fire_enter;

    wdt_key_decode #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .enable(!wdt_off), .cmd(cmd)
    );

    wdt_period_sel #(.BASE_CYCLES(BASE_CYCLES), .CNT_W(CNT_W)) u_per (
        .rate(rate_sel), .period(load_val)
    );

    wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(por_n), .load(cnt_load), .load_val(load_val),
        .dec(cnt_dec), .cnt(cnt), .last(cnt_last)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cmd.arm) state_nx = ST_COUNT;
            ST_COUNT: begin
                if (wdt_off || cmd.clr) state_nx = ST_IDLE;
                else if (cmd.arm)       state_nx = ST_COUNT;
                else if (cnt_last)      state_nx = ST_FIRE;
            end
            ST_FIRE:  if (pcnt == '0) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    assign cnt_load   = cmd.arm && (state != ST_FIRE);
    assign cnt_dec    = (state == ST_COUNT) && !cmd.arm && !cmd.clr && !wdt_off;
    assign fire_enter = (state == ST_COUNT) && (state_nx == ST_FIRE);

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // pulse length and sticky flag
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pcnt         <= '0;
            timeout_flag <= 1'b0;
        end else begin
            if (fire_enter) begin
                pcnt         <= PW_W'(PULSE_W - 1);
                timeout_flag <= 1'b1;
            end else if (state == ST_FIRE && pcnt != '0) begin
                pcnt <= pcnt - PW_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        sys_rst = (state == ST_FIRE);
    end

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
        timeout_flag |=> timeout_flag);

    a_r9_flag_with_pulse: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |-> timeout_flag);

    a_r4_clear_stops: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_COUNT && cmd.clr) |=> (state == ST_IDLE));

    a_r10_off_stops: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_COUNT && wdt_off) |=> (state == ST_IDLE && !sys_rst));

    a_r6_reload: assert property (@(posedge clk) disable iff (!por_n)
        (state != ST_FIRE && cmd.arm) |=> (cnt == $past(load_val)));

    a_r2_countdown: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_COUNT && !cmd.arm && !cmd.clr && !wdt_off && !cnt_last)
        |=> (state == ST_COUNT && cnt == $past(cnt) - CNT_W'(1)));

    a_r8_pulse_end: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_FIRE && pcnt == '0) |=> (state == ST_IDLE && !sys_rst));
endmodule

// File: tb/tb_wdt_keyed_top.sv
module tb_wdt_keyed_top;
    localparam int BASE = 16;
    localparam int PW   = 3;
    localparam logic [3:0] SVC = 4'h3;

    logic       clk = 0;
    logic       por_n = 0;
    logic       wr_en = 0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wdt_off = 0;
    logic [1:0] rate_sel = '0;
    logic       sys_rst, timeout_flag;

    int total = 0, bad = 0;
    bit finished = 0;

    wdt_keyed_top #(.ADDR_W(4), .SVC_ADDR(SVC), .BASE_CYCLES(BASE), .PULSE_W(PW)) dut (
        .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wdt_off(wdt_off), .rate_sel(rate_sel),
        .sys_rst(sys_rst), .timeout_flag(timeout_flag)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; the following posedge captures the write
    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic expect_fire(input int p, input string req);
        repeat (p - 1) @(negedge clk);
        check(sys_rst == 0, req, int'(sys_rst), 0);
        @(negedge clk);
        check(sys_rst == 1, req, int'(sys_rst), 1);
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (sys_rst && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sys_rst) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    task automatic do_por();
        @(negedge clk); por_n = 0;
        @(negedge clk); por_n = 1;
        @(negedge clk);
    endtask

    function automatic int per(input int r);
        return BASE << (2 * r);
    endfunction

    initial begin
        int n;
        repeat (3) @(negedge clk);
        por_n = 1;
        @(negedge clk);
        // R1 reset state
        check(sys_rst == 0, "R1 sys_rst", int'(sys_rst), 0);
        check(timeout_flag == 0, "R1 flag", int'(timeout_flag), 0);
        quiet(10, "R1 idle quiet");

        // R2/R3/R8/R9 sweep over all rates
        for (int r = 0; r < 4; r++) begin
            do_por();
            rate_sel = 2'(r);
            do_write(SVC, 8'h55);
            expect_fire(per(r), "R3 period sweep");
            check(timeout_flag == 1, "R9 flag with pulse", int'(timeout_flag), 1);
            pulse_len(n);
            check(n == PW, "R8 pulse width", n, PW);
            quiet(5, "R8 idle after pulse");
        end

        // R9 flag survives key writes, cleared by por only
        do_write(SVC, 8'h55);
        repeat (3) @(negedge clk);
        do_write(SVC, 8'hAA);
        check(timeout_flag == 1, "R9 sticky", int'(timeout_flag), 1);
        do_por();
        check(timeout_flag == 0, "R9 por clears", int'(timeout_flag), 0);

        // R4 clear mid-count and on the expiring edge
        rate_sel = 0;
        do_write(SVC, 8'h55);
        repeat (5) @(negedge clk);
        do_write(SVC, 8'hAA);
        quiet(3 * BASE, "R4 clear mid");
        do_write(SVC, 8'h55);
        repeat (BASE - 1) @(negedge clk);
        do_write(SVC, 8'hAA);
        check(sys_rst == 0, "R4 clear last edge", int'(sys_rst), 0);
        quiet(3 * BASE, "R4 clear last quiet");

        // R5 foreign writes ignored
        do_write(SVC, 8'h55);
        do_write(SVC, 8'h12);
        do_write(4'h5, 8'h55);
        do_write(4'h6, 8'hAA);
        expect_fire(BASE - 3, "R5 expiry unchanged");
        pulse_len(n);
        do_write(SVC, 8'h33);
        do_write(4'h1, 8'h55);
        quiet(3 * BASE, "R5 idle stays idle");

        // R6 re-arm reloads
        do_por();
        do_write(SVC, 8'h55);
        repeat (4) @(negedge clk);
        do_write(SVC, 8'h55);
        expect_fire(BASE, "R6 reload");
        pulse_len(n);

        // R7 rate sampled at arm
        rate_sel = 1;
        do_write(SVC, 8'h55);
        rate_sel = 3;
        repeat (10) @(negedge clk);
        rate_sel = 0;
        expect_fire(per(1) - 10, "R7 rate latched");
        pulse_len(n);

        // R8 writes during pulse ignored
        rate_sel = 0;
        do_write(SVC, 8'h55);
        expect_fire(BASE, "R8 fire");
        do_write(SVC, 8'hAA);
        pulse_len(n);
        check(n == PW - 1, "R8 width with writes", n, PW - 1);
        do_write(SVC, 8'h55);
        do_write(SVC, 8'hAA);
        quiet(2 * BASE, "R8 no rearm from pulse");

        // R10 disable
        wdt_off = 1;
        do_write(SVC, 8'h55);
        quiet(3 * BASE, "R10 arm ignored");
        wdt_off = 0;
        do_write(SVC, 8'h55);
        repeat (5) @(negedge clk);
        wdt_off = 1;
        @(negedge clk);
        wdt_off = 0;
        quiet(3 * BASE, "R10 off stops count");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(negedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule